// File: doc/BRIEF.md
# ULPI Link Register Access Controller

This block sits on the link side of a ULPI transceiver connection. It runs the register read and register write sequences over the 8-bit data bus and follows the transceiver's DIR and NXT handshake signals. A request port takes a direction bit, an extended-addressing flag, an 8-bit register address and a write byte. When the operation completes, the block raises a one-cycle done pulse. For a read, the returned byte appears on the same cycle as the pulse.

Registers reached through the immediate form use the low six address bits inside the command byte. When the extended flag is set, the command byte carries the escape address 2Fh, and the full 8-bit address follows in its own phase. The transceiver can take the bus at any point by raising DIR. When that happens, the controller releases the bus and waits for DIR to return low. After one idle cycle it restarts the same operation from its command byte. The requester does not see these retries.

Top module: `ulpi_reg_ctrl`

## Requirements
- R1: After reset the controller is idle: `req_ready` is high while DIR is low, `ulpi_data_oe`, `ulpi_stp` and `done` are low.
- R2: The command byte is `{2'b10, a}` for a write and `{2'b11, a}` for a read. Here `a` is `req_addr[5:0]` for an immediate access and 6'h2F for an extended access. An extended access drives the full `req_addr` byte in the phase after the command.
- R3: Each link-driven byte (command, extended address, write data) stays on the bus until NXT is sampled high. The next phase starts in the following cycle. Request inputs are captured at acceptance, so later changes to them have no effect.
- R4: A write ends with one cycle in which `ulpi_stp` is high and 8'h00 is driven. This cycle is the one after the final NXT: the second NXT for an immediate write, the third for an extended write. `done` follows one cycle later.
- R5: A read expects DIR high in the cycle after the final NXT and samples the data bus one cycle later. `done` and `rdata` carrying that byte follow in the next cycle.
- R6: `ulpi_data_oe` is low whenever DIR is high, in the turnaround cycle that awaits DIR after a read command, and in the idle cycle after an abort.
- R7: DIR sampled high during any link-driven phase aborts the operation. Once DIR is low again, one idle cycle passes and the same command byte is driven again.
- R8: In the read data cycle, NXT high together with DIR high marks a receive event. The read is dropped without `done`, and the operation is retried as in R7.
- R9: A request is accepted only while `req_ready` is high. `req_ready` is high only when the controller is idle and DIR is low. A request presented while DIR is high is ignored.
- R10: `done` is high for exactly one cycle per completed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_ext | input | 1 | Use extended addressing |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller can accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte, valid with `done` |
| ulpi_dir | input | 1 | Bus direction from transceiver |
| ulpi_nxt | input | 1 | Transceiver throttle |
| ulpi_stp | output | 1 | Stop strobe |
| ulpi_data_in | input | 8 | Data bus as driven by transceiver |
| ulpi_data_out | output | 8 | Data bus value driven by link |
| ulpi_data_oe | output | 1 | Link drives the data bus |

## Verification
The embedded properties check several rules on every cycle. STP comes only after an NXT and lasts one cycle. `done` never lasts longer than one cycle. A read's `done` always follows a data cycle in which DIR was high and NXT low. A write's `done` always follows STP. Other behaviour depends on a transceiver sequence, so only the bench's scenarios can show it. This covers the byte order of each phase, the handling of NXT latency, the restart after an abort injected at every phase, and the read dropped by a receive event. The bench sweeps all four operation kinds across every abort point and two NXT latencies.

// File: rtl/ulpi_reg_ctrl.sv
module ulpi_reg_ctrl #(
  parameter logic [5:0] ESC_ADDR = 6'h2F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       req_ext,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       req_ready,
  output logic       done,
  output logic [7:0] rdata,
  input  logic       ulpi_dir,
  input  logic       ulpi_nxt,
  output logic       ulpi_stp,
  input  logic [7:0] ulpi_data_in,
  output logic [7:0] ulpi_data_out,
  output logic       ulpi_data_oe
);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_EADR, S_WDAT, S_STP, S_RTRN, S_RDAT, S_RBCK, S_ABRT, S_GAP
  } st_t;

  st_t        st, st_n;
  logic       op_wr, op_ext;
  logic [7:0] op_addr, op_wdata;
  logic       drive;

  assign req_ready = (st == S_IDLE) && !ulpi_dir;
  assign ulpi_stp  = (st == S_STP);
  assign drive     = (st == S_CMD) || (st == S_EADR) || (st == S_WDAT) || (st == S_STP);
  assign ulpi_data_oe = drive && !ulpi_dir;

  always_comb begin
    case (st)
      S_CMD:   ulpi_data_out = {1'b1, !op_wr, op_ext ? ESC_ADDR : op_addr[5:0]};
      S_EADR:  ulpi_data_out = op_addr;
      S_WDAT:  ulpi_data_out = op_wdata;
      default: ulpi_data_out = 8'h00;
    endcase
  end

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE: if (req_valid && req_ready) st_n = S_CMD;
      S_CMD: begin
        if (ulpi_dir)      st_n = S_ABRT;
        else if (ulpi_nxt) st_n = op_ext ? S_EADR : (op_wr ? S_WDAT : S_RTRN);
      end
      S_EADR: begin
        if (ulpi_dir)      st_n = S_ABRT;
        else if (ulpi_nxt) st_n = op_wr ? S_WDAT : S_RTRN;
      end
      S_WDAT: begin
        if (ulpi_dir)      st_n = S_ABRT;
        else if (ulpi_nxt) st_n = S_STP;
      end
      S_STP:  st_n = ulpi_dir ? S_ABRT : S_IDLE;
      S_RTRN: st_n = ulpi_dir ? S_RDAT : S_ABRT;
      S_RDAT: st_n = (!ulpi_dir || ulpi_nxt) ? S_ABRT : S_RBCK;
      S_RBCK: if (!ulpi_dir) st_n = S_IDLE;
      S_ABRT: if (!ulpi_dir) st_n = S_GAP;
      S_GAP:  st_n = ulpi_dir ? S_ABRT : S_CMD;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_wr    <= 1'b0;
      op_ext   <= 1'b0;
      op_addr  <= 8'h00;
      op_wdata <= 8'h00;
      done     <= 1'b0;
      rdata    <= 8'h00;
    end else begin
      st   <= st_n;
      done <= 1'b0;
      if (st == S_IDLE && req_valid && req_ready) begin
        op_wr    <= req_write;
        op_ext   <= req_ext;
        op_addr  <= req_addr;
        op_wdata <= req_wdata;
      end
      if (st == S_STP && !ulpi_dir) done <= 1'b1;
      if (st == S_RDAT && ulpi_dir && !ulpi_nxt) begin
        done  <= 1'b1;
        rdata <= ulpi_data_in;
      end
    end
  end

  assert_stp_after_nxt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |-> $past(ulpi_nxt));
  assert_stp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |=> !ulpi_stp);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_read_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_wr) |-> ($past(ulpi_dir) && !$past(ulpi_nxt)));
  assert_write_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_wr) |-> $past(ulpi_stp));
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ulpi_dir) && !ulpi_dir && !done |-> !ulpi_stp);

endmodule

// File: tb/sim_ulpi_reg_ctrl.sv
module sim_ulpi_reg_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ext = 1'b0;
  logic [7:0] req_addr = 8'h00, req_wdata = 8'h00;
  logic req_ready, done, ulpi_stp, ulpi_data_oe;
  logic [7:0] rdata, ulpi_data_out;
  logic ulpi_dir = 1'b0, ulpi_nxt = 1'b0;
  logic [7:0] ulpi_data_in = 8'h00;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ulpi_reg_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ext(req_ext), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata), .ulpi_dir(ulpi_dir),
    .ulpi_nxt(ulpi_nxt), .ulpi_stp(ulpi_stp), .ulpi_data_in(ulpi_data_in),
    .ulpi_data_out(ulpi_data_out), .ulpi_data_oe(ulpi_data_oe)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic run(input bit wr, input bit ext, input logic [7:0] ad,
                     input logic [7:0] wd, input logic [7:0] rd,
                     input int ab, input int lat);
    int hs;
    logic [7:0] tx, eb;
    hs = (wr ? 2 : 1) + (ext ? 1 : 0);
    tx = {1'b1, !wr, ext ? 6'h2F : ad[5:0]};
    @(negedge clk);
    chk("R9 ready when idle", req_ready, 1);
    req_valid = 1; req_write = wr; req_ext = ext; req_addr = ad; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_addr = ~ad; req_wdata = ~wd; req_write = !wr; req_ext = !ext;
    for (int att = 0; att < 2; att++) begin
      bit doab, cut;
      doab = (att == 0) && (ab >= 0);
      cut = 0;
      for (int h = 0; h < hs && !cut; h++) begin
        eb = (h == 0) ? tx : (ext && h == 1) ? ad : wd;
        for (int w = 0; w <= lat; w++) begin
          chk("R3 oe held", ulpi_data_oe, 1);
          chk("R2 phase byte", ulpi_data_out, eb);
          chk("R3 no stp", ulpi_stp, 0);
          if (w < lat) @(negedge clk);
        end
        if (doab && h == ab) begin
          ulpi_dir = 1; cut = 1;
          #0 chk("R6 release on dir", ulpi_data_oe, 0);
        end else begin
          ulpi_nxt = 1; @(negedge clk); ulpi_nxt = 0;
        end
      end
      if (!cut) begin
        if (wr) begin
          chk("R4 stp", ulpi_stp, 1);
          chk("R4 stp oe", ulpi_data_oe, 1);
          chk("R4 stp data", ulpi_data_out, 8'h00);
          @(negedge clk);
          chk("R4 write done", done, 1);
          chk("R4 stp single", ulpi_stp, 0);
          @(negedge clk);
          chk("R10 done width", done, 0);
          return;
        end else begin
          chk("R6 turnaround oe", ulpi_data_oe, 0);
          chk("R5 no early done", done, 0);
          ulpi_dir = 1;
          @(negedge clk);
          chk("R6 oe under dir", ulpi_data_oe, 0);
          ulpi_data_in = rd;
          if (doab && ab == hs) begin
            ulpi_nxt = 1; cut = 1;
          end else begin
            @(negedge clk);
            chk("R5 read done", done, 1);
            chk("R5 read data", rdata, rd);
            ulpi_dir = 0;
            @(negedge clk);
            chk("R10 done width", done, 0);
            chk("R6 oe after read", ulpi_data_oe, 0);
            return;
          end
        end
      end
      @(negedge clk);
      ulpi_nxt = 0;
      chk("R6 oe in abort", ulpi_data_oe, 0);
      chk("R8 no done on abort", done, 0);
      ulpi_dir = 0;
      @(negedge clk);
      chk("R7 idle gap", ulpi_data_oe, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 oe", ulpi_data_oe, 0);
    chk("R1 stp", ulpi_stp, 0);
    chk("R1 done", done, 0);

    ulpi_dir = 1; req_valid = 1; req_write = 1; req_addr = 8'h05;
    @(negedge clk);
    req_valid = 0;
    chk("R9 busy bus not ready", req_ready, 0);
    ulpi_dir = 0;
    @(negedge clk);
    chk("R9 ignored request no drive", ulpi_data_oe, 0);
    chk("R9 still idle", req_ready, 1);

    n = 0;
    for (int wr = 0; wr < 2; wr++)
      for (int ex = 0; ex < 2; ex++) begin
        int hs;
        hs = (wr ? 2 : 1) + ex;
        for (int ab = -1; ab <= (wr ? hs - 1 : hs); ab++)
          for (int lat = 0; lat < 2; lat++) begin
            logic [7:0] ad;
            ad = ex ? 8'h30 + 8'(n * 7) : 8'(n * 13);
            run(wr[0], ex[0], ad, 8'hA5 ^ 8'(n), 8'h3C + 8'(n * 3), ab, lat);
            n++;
          end
      end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule